// File: doc/BRIEF.md
# Segmented Bus-Invert Transition Encoder

This block reduces the number of lines that switch on a wide parallel bus. On the transmit side, a registered encoder keeps the value it last drove, flag lines included. For each accepted data word, it works out how many lines would change if the word went out as it is. If sending the complement would change fewer lines, it sends the complement and raises a per-segment invert line. A combinational decoder on the receive side uses those invert lines to restore the original word.

The bus is cut into `SEGS` equal slices. Each slice has its own invert line and makes its own choice. Setting `SEGS` to 1 gives a single decision for the whole bus. The top module contains the encoder and the decoder wired back to back, so the decoded word can be watched next to the coded bus.

Top module: `pbi_codec`

## Requirements
- R1: While `rst_n` is low at a clock edge, the encoder clears its coded bus and every invert line to zero. The decoded output is therefore zero after reset.
- R2: For each segment, the cost of a word is the number of that segment's data lines that differ from the stored bus value. If the segment's stored invert line is 1, the cost is one higher, because that line would fall.
- R3: A segment is sent complemented, with its invert line set to 1, only when twice the cost is strictly greater than (segment width + 1). On a tie, the word is sent unchanged with the invert line at 0.
- R4: For each accepted word and each segment, the number of lines that change is at most floor((segment width + 1) / 2). The lines counted are the segment's data lines plus its invert line.
- R5: The reference for the next cost is the coded value that was actually driven, invert lines included, not the raw data previously accepted.
- R6: A cycle with `in_valid` low leaves `bus_data` and `bus_flag` unchanged.
- R7: The coded bus updates one clock edge after a word is accepted. `out_data` is combinational from the coded bus, and equals the word accepted at the most recent edge with `in_valid` high.
- R8: Segment k occupies `bus_data[k*SEG_W +: SEG_W]` with `SEG_W = WIDTH/SEGS`, and its invert line is `bus_flag[k]`. Each segment decides independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accept `in_data` at this edge |
| in_data | input | WIDTH | Raw word to transmit |
| bus_data | output | WIDTH | Coded bus lines (registered) |
| bus_flag | output | SEGS | Per-segment invert lines (registered) |
| out_data | output | WIDTH | Decoded word from the receive side |

## Verification
With the default shape of three data lines per segment, the cost can land exactly on half the line count. The bench drives that tie, and a design that inverts on ties would raise an invert line and toggle more lines than necessary. It also drives words whose segments disagree on inversion; a design that shares one decision, or that swaps flag order, would mismatch the per-segment expectation. Long random streams and idle gaps check the following points:
- The cost must include the falling invert line. A design that leaves it out would exceed the toggle bound after an inverted word.
- The reference must be the coded bus rather than the raw data. A design that uses the raw data would pick the wrong polarity.
- The bus must hold during idle cycles. A design that does not hold would switch lines with `in_valid` low.

// File: rtl/pbi_pkg.sv
// Package pbi_pkg
// Shared helpers for the segmented bus-invert codec: how many lines a
// segment owns and the rule that turns a cost into an invert decision.
package pbi_pkg;

    // Lines owned by one segment: its data lines plus its invert line.
    function automatic int unsigned seg_lines(input int unsigned seg_w);
        return seg_w + 1;
    endfunction

    // Invert only when the plain-send cost is a strict majority of the lines.
    function automatic logic want_invert(input int unsigned cost,
                                         input int unsigned lines);
        return (2 * cost) > lines;
    endfunction

endpackage

// File: rtl/pbi_popcount.sv
// Module pbi_popcount
// Counts the ones in an N-bit vector. Purely combinational.
// Assumes N >= 1; the result width holds the value N.
module pbi_popcount #(
    parameter int N  = 4,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] count
);

    // Sum the bits one at a time; the tool builds an adder tree.
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(vec[i]);
        end
    end

endmodule

// File: rtl/pbi_seg_encoder.sv
// Module pbi_seg_encoder
// Encoder for one bus segment. It holds the segment's coded lines and invert
// line, prices a plain send against the held value, and complements the
// segment when that lowers the number of switching lines.
// Assumes SEG_W >= 1 and a synchronous active-low reset.
module pbi_seg_encoder
    import pbi_pkg::*;
#(
    parameter int SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [SEG_W-1:0] seg_in,
    output logic [SEG_W-1:0] seg_bus,
    output logic             seg_flag
);

    localparam int LINES = SEG_W + 1;
    localparam int CW    = $clog2(LINES + 1);

    logic [LINES-1:0] plain_diff;
    logic [CW-1:0]    plain_cost;
    logic             invert;
    logic [SEG_W-1:0] next_bus;

    // Lines that would switch if the word went out plain with its flag at 0.
    always_comb begin
        plain_diff = {seg_flag, seg_in ^ seg_bus};
    end

    pbi_popcount #(.N(LINES)) u_cost (
        .vec   (plain_diff),
        .count (plain_cost)
    );

    // Choose polarity; a tie keeps the plain word.
    always_comb begin
        invert   = want_invert(int'(plain_cost), seg_lines(SEG_W));
        next_bus = invert ? ~seg_in : seg_in;
    end

    // Register the coded segment on accepted words; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_bus  <= '0;
            seg_flag <= 1'b0;
        end else if (valid) begin
            seg_bus  <= next_bus;
            seg_flag <= invert;
        end
    end

endmodule

// File: rtl/pbi_decoder.sv
// Module pbi_decoder
// Receive-side decoder: each segment is XORed with its own invert line
// copied across the segment. Purely combinational.
// Assumes WIDTH is a whole multiple of SEGS.
module pbi_decoder #(
    parameter int WIDTH = 12,
    parameter int SEGS  = 4,
    localparam int SEG_W = WIDTH / SEGS
) (
    input  logic [WIDTH-1:0] bus_data,
    input  logic [SEGS-1:0]  bus_flag,
    output logic [WIDTH-1:0] data
);

    for (genvar k = 0; k < SEGS; k++) begin : g_seg
        // Undo the complement for segment k.
        always_comb begin
            data[k*SEG_W +: SEG_W] = bus_data[k*SEG_W +: SEG_W] ^ {SEG_W{bus_flag[k]}};
        end
    end

endmodule

// File: rtl/pbi_codec.sv
// Module pbi_codec
// Top of the segmented bus-invert codec: one encoder per segment drives the
// coded bus and invert lines, and the decoder restores the word beside it.
// Assumes WIDTH % SEGS == 0; SEGS = 1 gives whole-bus inversion.
module pbi_codec #(
    parameter int WIDTH = 12,
    parameter int SEGS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic [WIDTH-1:0] bus_data,
    output logic [SEGS-1:0]  bus_flag,
    output logic [WIDTH-1:0] out_data
);

    localparam int SEG_W = WIDTH / SEGS;

    // Elaboration-time guard on the segment split.
    initial begin
        if (WIDTH % SEGS != 0) begin
            $error("pbi_codec: WIDTH must be a multiple of SEGS");
        end
    end

    for (genvar k = 0; k < SEGS; k++) begin : g_enc
        pbi_seg_encoder #(.SEG_W(SEG_W)) u_enc (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid    (in_valid),
            .seg_in   (in_data[k*SEG_W +: SEG_W]),
            .seg_bus  (bus_data[k*SEG_W +: SEG_W]),
            .seg_flag (bus_flag[k])
        );
    end

    pbi_decoder #(.WIDTH(WIDTH), .SEGS(SEGS)) u_dec (
        .bus_data (bus_data),
        .bus_flag (bus_flag),
        .data     (out_data)
    );

endmodule

// File: rtl/pbi_codec_checker.sv
// Module pbi_codec_checker
// Temporal checks on the codec's ports, attached to every pbi_codec by bind.
module pbi_codec_checker #(
    parameter int WIDTH = 12,
    parameter int SEGS  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_data,
    input logic [WIDTH-1:0] bus_data,
    input logic [SEGS-1:0]  bus_flag,
    input logic [WIDTH-1:0] out_data
);

    localparam int SEG_W = WIDTH / SEGS;
    localparam int BOUND = (SEG_W + 1) / 2;

    // R1: the first cycle out of reset shows a cleared bus.
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (bus_data == '0 && bus_flag == '0 && out_data == '0));

    // R6: an idle cycle leaves every line unchanged.
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(bus_data) && $stable(bus_flag)));

    // R7: the decoded word is the word accepted at the previous edge.
    a_r7_decode_match: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data == $past(in_data)));

    for (genvar k = 0; k < SEGS; k++) begin : g_seg
        // R4: per-segment switching stays within half the segment's lines.
        a_r4_toggle_bound: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(bus_data[k*SEG_W +: SEG_W] ^ $past(bus_data[k*SEG_W +: SEG_W]))
             + $countones(bus_flag[k] ^ $past(bus_flag[k]))) <= BOUND);
    end

endmodule

bind pbi_codec pbi_codec_checker #(.WIDTH(WIDTH), .SEGS(SEGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .bus_data (bus_data),
    .bus_flag (bus_flag),
    .out_data (out_data)
);

// File: tb/pbi_codec_tb.sv
// Scoreboard bench for pbi_codec: the driver pushes the expected coded value
// of each word; the monitor pops and compares once the design has registered it.
module pbi_codec_tb;

    localparam int  WIDTH  = 12;
    localparam int  SEGS   = 4;
    localparam int  SEG_W  = WIDTH / SEGS;
    localparam int  BOUND  = (SEG_W + 1) / 2;
    localparam time T_CLK  = 10ns;

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] bus;
        logic [SEGS-1:0]  flag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic [WIDTH-1:0] bus_data;
    logic [SEGS-1:0]  bus_flag;
    logic [WIDTH-1:0] out_data;

    int checks = 0;
    int errors = 0;

    item_t            sb[$];
    logic [WIDTH-1:0] m_bus  = '0;
    logic [SEGS-1:0]  m_flag = '0;
    logic             cap_v  = 1'b0;
    logic             cap_r  = 1'b0;

    pbi_codec #(.WIDTH(WIDTH), .SEGS(SEGS)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .bus_data (bus_data),
        .bus_flag (bus_flag),
        .out_data (out_data)
    );

    always #(T_CLK / 2) clk = ~clk;

    // Record what the design saw at each rising edge.
    always @(posedge clk) begin
        cap_v <= in_valid;
        cap_r <= rst_n;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference coder built from R2, R3, R5 and R8.
    task automatic push_word(input logic [WIDTH-1:0] d);
        item_t it;
        it.data = d;
        for (int k = 0; k < SEGS; k++) begin
            logic [SEG_W-1:0] ds, ps;
            int cost;
            ds   = d[k*SEG_W +: SEG_W];
            ps   = m_bus[k*SEG_W +: SEG_W];
            cost = $countones(ds ^ ps) + int'(m_flag[k]);
            if (2 * cost > SEG_W + 1) begin
                it.bus[k*SEG_W +: SEG_W] = ~ds;
                it.flag[k] = 1'b1;
            end else begin
                it.bus[k*SEG_W +: SEG_W] = ds;
                it.flag[k] = 1'b0;
            end
        end
        m_bus  = it.bus;
        m_flag = it.flag;
        sb.push_back(it);
    endtask

    task automatic send(input logic [WIDTH-1:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        push_word(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = in_data ^ WIDTH'(12'hA5C);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        m_bus = '0;
        m_flag = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare outputs after each edge (R2..R8 and R1 after reset).
    logic [WIDTH-1:0] last_bus  = '0;
    logic [SEGS-1:0]  last_flag = '0;
    always @(negedge clk) begin
        if (!cap_r) begin
            last_bus  = '0;
            last_flag = '0;
            sb.delete();
        end else begin
            if (cap_v && sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(bus_data == it.bus, "R3/R5", "coded bus", bus_data, it.bus);
                check(bus_flag == it.flag, "R2/R8", "invert lines",
                      WIDTH'(bus_flag), WIDTH'(it.flag));
                check(out_data == it.data, "R7", "decoded word", out_data, it.data);
            end else if (!cap_v) begin
                check(bus_data == last_bus && bus_flag == last_flag, "R6",
                      "idle hold", bus_data, last_bus);
            end
            for (int k = 0; k < SEGS; k++) begin
                int t;
                t = $countones(bus_data[k*SEG_W +: SEG_W] ^ last_bus[k*SEG_W +: SEG_W])
                    + int'(bus_flag[k] ^ last_flag[k]);
                check(t <= BOUND, "R4", "segment toggles", WIDTH'(t), WIDTH'(BOUND));
            end
            last_bus  = bus_data;
            last_flag = bus_flag;
        end
    end

    // Watchdog.
    initial begin
        #(T_CLK * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_data == '0 && bus_flag == '0 && out_data == '0, "R1",
              "reset state", bus_data, '0);

        // R3: all ones against a zero bus inverts every segment.
        send(12'hFFF);
        @(negedge clk);
        in_valid = 1'b0;
        check(bus_data == 12'h000 && bus_flag == 4'hF, "R3", "full invert",
              {bus_data[WIDTH-1:4], bus_flag}, 12'h00F);
        idle(1);

        // R2: flags at 1 add a falling line; zero data stays plain.
        send(12'h000);
        @(negedge clk);
        in_valid = 1'b0;
        check(bus_flag == 4'h0 && bus_data == 12'h000, "R2", "flag counted",
              WIDTH'(bus_flag), 12'h000);

        // R3 tie: two of four lines switch, word stays plain.
        send(12'h6DB);
        @(negedge clk);
        in_valid = 1'b0;
        check(bus_data == 12'h6DB && bus_flag == 4'h0, "R3", "tie kept plain",
              bus_data, 12'h6DB);

        // R8: only segment 2 inverts.
        do_reset();
        send(12'h1C0);
        @(negedge clk);
        in_valid = 1'b0;
        check(bus_data == 12'h000 && bus_flag == 4'b0100, "R8", "independent segments",
              WIDTH'(bus_flag), 12'h004);

        // R5/R6/R7: random stream with idle gaps.
        for (int i = 0; i < 400; i++) begin
            send(WIDTH'($urandom));
            if ((i % 7) == 3) idle(2);
        end
        idle(2);

        // R1 again, mid-run.
        do_reset();
        @(negedge clk);
        check(bus_data == '0 && bus_flag == '0, "R1", "mid-run reset", bus_data, '0);

        for (int i = 0; i < 200; i++) begin
            send(WIDTH'($urandom) | WIDTH'(12'h924));
        end
        idle(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule